// File: doc/BRIEF.md
# Host Register Window and Interrupt Gatherer

This block sits between a host I/O bus and the internal subunits of a two-channel line adapter. The host sees a 32-byte region. The lower half holds a few fixed, configuration and status bytes. The upper half is a shared data window. A selector byte decides which internal subunit the window reaches: one of the two framing channels, the line-controller FIFO, or one of the two register banks of the line controller. Host software picks the high bank for line-controller register numbers above 0x2F and the low bank otherwise. Inside the chosen subunit, only the low four address bits are presented.

The block also collects interrupt requests. These come from the line controller, from the framing pair and from an internal interval timer. It shows them as an active-low pending field and drives one interrupt line that may be shared with other devices. A pending field that reads all ones tells the host that the interrupt came from some other device. Control bits give the host a device reset for the subunits, timer hold and reload, an interrupt enable and a scratch test bit.

Top module: `hostwin_glue`

## Requirements
- R1: After the synchronous reset the control byte, the configuration byte and the selector are 0. With no requests, offset 2 reads 0x07. `irq_out` and `sub_rst` are 0.
- R2: Offset 0 reads the class code parameter and offset 1 reads the revision parameter. Writes to either offset have no effect.
- R3: The selector is written and read at offset 4 (bits 2:0, upper bits read 0). Selector 0 asserts `sub_cs[0]` (framing channel A). Selector 1 asserts `sub_cs[1]` (channel B). Selector 2 asserts `sub_cs[2]` (line-controller FIFO). Selector 4 asserts `sub_cs[3]` (low bank) and selector 6 asserts `sub_cs[4]` (high bank). Any other selector value asserts no chip select, and window reads then return 0xFF. At most one chip select is ever active.
- R4: An access at offsets 0x10 to 0x1F asserts the selected chip select for that cycle. On a write it also pulses `sub_wr`, and on a read it pulses `sub_rd`. `sub_addr` carries the offset's low four bits, `sub_wdata` carries the host data, and a read returns `sub_rdata` on `host_rdata` in the same cycle.
- R5: Offset 2 bits 2:0 are active-low pending flags: bit 0 for the line controller, bit 1 for the framing pair, bit 2 for the timer.
- R6: A write to offset 2 loads the control bits: bit 0 device reset, bit 1 timer hold, bit 2 timer reload, bit 3 interrupt enable, bit 4 test bit. The test bit reads back at offset 2 bit 4. Bits 3 and 7:5 of offset 2 read 0.
- R7: Offset 3 stores all eight written bits and reads them back. Bit 7 drives `iom_en` and bits 3:0 drive `irq_line_sel`.
- R8: While the device-reset bit is 1, `sub_rst` is 1. From the next cycle on, the selector is held at 0 and selector writes are ignored.
- R9: `irq_out` is 1 exactly when the interrupt enable is 1 and at least one pending flag reads 0. It follows request changes in the same cycle.
- R10: The timer advances one step per cycle unless held. On the step from TIMER_TC-1 it wraps to 0 and sets the timer pending flag, which stays set. While the reload bit is 1, the count returns to 0 and the pending flag clears.
- R11: Offsets 5 to 15 read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Byte offset within the 32-byte region |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from the address |
| sub_cs | output | 5 | One-hot subunit chip selects during window access |
| sub_addr | output | ADDR_W-1 | Address inside the selected subunit |
| sub_rd | output | 1 | Subunit read strobe |
| sub_wr | output | 1 | Subunit write strobe |
| sub_wdata | output | DATA_W | Subunit write data |
| sub_rdata | input | DATA_W | Read data from the selected subunit |
| sub_rst | output | 1 | Reset held on all subunits |
| lc_irq | input | 1 | Line-controller request, active high |
| hdlc_irq | input | 1 | Framing-pair request, active high |
| irq_out | output | 1 | Shared interrupt line, active high |
| iom_en | output | 1 | Serial subscriber-bus enable |
| irq_line_sel | output | 4 | Interrupt line selection |

## Verification
A wrong selector shows up at the very next window access. The wrong chip select rises, or a window read returns 0xFF instead of subunit data. A slip in the control byte shows up on `irq_out` or `sub_rst` within one cycle. A timer that miscounts is exposed when the pending flag at offset 2 bit 2, and the interrupt with it, arrives too early, too late or not at all after a known number of free-running cycles. A behavioural model in the bench tracks every register and the timer, and it checks all outputs on every cycle.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

    localparam int NUM_UNITS = 5;

    // register offsets in the lower half of the region
    localparam logic [3:0] OFS_CLASS  = 4'd0;
    localparam logic [3:0] OFS_REV    = 4'd1;
    localparam logic [3:0] OFS_STATUS = 4'd2;
    localparam logic [3:0] OFS_CONFIG = 4'd3;
    localparam logic [3:0] OFS_INDEX  = 4'd4;

    typedef enum logic [2:0] {
        SEL_CHAN_A  = 3'd0,
        SEL_CHAN_B  = 3'd1,
        SEL_LC_FIFO = 3'd2,
        SEL_LC_LOW  = 3'd4,
        SEL_LC_HIGH = 3'd6
    } unit_sel_e;

    typedef struct packed {
        logic test_bit;
        logic irq_enable;
        logic timer_reload;
        logic timer_hold;
        logic dev_reset;
    } ctrl_t;

    typedef struct packed {
        logic timer_n;
        logic pair_n;
        logic lc_n;
    } pend_n_t;

    function automatic logic [NUM_UNITS-1:0] unit_onehot(input logic [2:0] sel);
        unit_onehot = '0;
        case (sel)
            SEL_CHAN_A:  unit_onehot[0] = 1'b1;
            SEL_CHAN_B:  unit_onehot[1] = 1'b1;
            SEL_LC_FIFO: unit_onehot[2] = 1'b1;
            SEL_LC_LOW:  unit_onehot[3] = 1'b1;
            SEL_LC_HIGH: unit_onehot[4] = 1'b1;
            default:     unit_onehot = '0;
        endcase
    endfunction

endpackage

// File: rtl/hostwin_decode.sv
module hostwin_decode
    import hostwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           sel,
    input  logic                 win_access,
    input  logic                 rd,
    input  logic                 wr,
    output logic [NUM_UNITS-1:0] cs,
    output logic                 unit_valid,
    output logic                 sub_rd,
    output logic                 sub_wr
);

    logic [NUM_UNITS-1:0] onehot;

    assign onehot     = unit_onehot(sel);
    assign unit_valid = |onehot;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cs
        assign cs[u] = onehot[u] & win_access;
    end

    assign sub_rd = win_access & rd & unit_valid;
    assign sub_wr = win_access & wr & unit_valid;

    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs));

    assert_strobe_has_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (sub_rd || sub_wr) |-> ($countones(cs) == 1));

endmodule

// File: rtl/hostwin_timer.sv
module hostwin_timer #(
    parameter int TIMER_TC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic reload,
    output logic pend
);

    localparam int CW = (TIMER_TC > 1) ? $clog2(TIMER_TC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMER_TC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else if (reload) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else if (!hold) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                pend  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_tc_sets_pend_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(cnt_q) == LAST));

    assert_reload_clears_R10: assert property (@(posedge clk) disable iff (rst)
        reload |=> (!pend && cnt_q == '0));

    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (rst)
        (hold && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/hostwin_irq.sv
module hostwin_irq
    import hostwin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    irq_enable,
    input  logic    lc_req,
    input  logic    pair_req,
    input  logic    timer_pend,
    output pend_n_t stat_n,
    output logic    irq_out
);

    assign stat_n.lc_n    = ~lc_req;
    assign stat_n.pair_n  = ~pair_req;
    assign stat_n.timer_n = ~timer_pend;

    assign irq_out = irq_enable & ~(&stat_n);

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (lc_req || pair_req || timer_pend));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_enable |-> !irq_out);

endmodule

// File: rtl/hostwin_glue.sv
module hostwin_glue
    import hostwin_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  CLASS_CODE = 8'h5C,
    parameter logic [7:0]  REV_CODE   = 8'h03,
    parameter int          TIMER_TC   = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [NUM_UNITS-1:0] sub_cs,
    output logic [ADDR_W-2:0]    sub_addr,
    output logic                 sub_rd,
    output logic                 sub_wr,
    output logic [DATA_W-1:0]    sub_wdata,
    input  logic [DATA_W-1:0]    sub_rdata,
    output logic                 sub_rst,
    input  logic                 lc_irq,
    input  logic                 hdlc_irq,
    output logic                 irq_out,
    output logic                 iom_en,
    output logic [3:0]           irq_line_sel
);

    localparam int SUB_AW = ADDR_W - 1;

    ctrl_t               ctrl_q;
    logic [DATA_W-1:0]   cfg_q;
    logic [2:0]          sel_q;
    logic [SUB_AW-1:0]   reg_ofs;
    logic                in_regs;
    logic                win_access;
    logic                unit_valid;
    logic                timer_pend;
    pend_n_t             stat_n;
    logic [DATA_W-1:0]   status_byte;

    assign reg_ofs    = host_addr[SUB_AW-1:0];
    assign in_regs    = ~host_addr[ADDR_W-1];
    assign win_access = host_addr[ADDR_W-1] & (host_rd | host_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            sel_q  <= '0;
        end else begin
            if (host_wr && in_regs && reg_ofs == SUB_AW'(OFS_STATUS))
                ctrl_q <= ctrl_t'(host_wdata[4:0]);
            if (host_wr && in_regs && reg_ofs == SUB_AW'(OFS_CONFIG))
                cfg_q <= host_wdata;
            if (ctrl_q.dev_reset)
                sel_q <= '0;
            else if (host_wr && in_regs && reg_ofs == SUB_AW'(OFS_INDEX))
                sel_q <= host_wdata[2:0];
        end
    end

    hostwin_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel_q),
        .win_access (win_access),
        .rd         (host_rd),
        .wr         (host_wr),
        .cs         (sub_cs),
        .unit_valid (unit_valid),
        .sub_rd     (sub_rd),
        .sub_wr     (sub_wr)
    );

    hostwin_timer #(.TIMER_TC(TIMER_TC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .hold   (ctrl_q.timer_hold),
        .reload (ctrl_q.timer_reload),
        .pend   (timer_pend)
    );

    hostwin_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .irq_enable (ctrl_q.irq_enable),
        .lc_req     (lc_irq),
        .pair_req   (hdlc_irq),
        .timer_pend (timer_pend),
        .stat_n     (stat_n),
        .irq_out    (irq_out)
    );

    assign sub_addr     = reg_ofs;
    assign sub_wdata    = host_wdata;
    assign sub_rst      = ctrl_q.dev_reset;
    assign iom_en       = cfg_q[7];
    assign irq_line_sel = cfg_q[3:0];
    assign status_byte  = {3'b000, ctrl_q.test_bit, 1'b0, stat_n};

    always_comb begin
        host_rdata = '0;
        if (!in_regs) begin
            host_rdata = unit_valid ? sub_rdata : '1;
        end else begin
            case (reg_ofs)
                SUB_AW'(OFS_CLASS):  host_rdata = CLASS_CODE;
                SUB_AW'(OFS_REV):    host_rdata = REV_CODE;
                SUB_AW'(OFS_STATUS): host_rdata = status_byte;
                SUB_AW'(OFS_CONFIG): host_rdata = cfg_q;
                SUB_AW'(OFS_INDEX):  host_rdata = {{(DATA_W-3){1'b0}}, sel_q};
                default:             host_rdata = '0;
            endcase
        end
    end

    assert_sel_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.dev_reset |=> (sel_q == 3'd0));

    assert_window_read_R4: assert property (@(posedge clk) disable iff (rst)
        sub_rd |-> (host_rdata == sub_rdata));

endmodule

// File: tb/hostwin_glue_bench.sv
`timescale 1ns/1ps
module hostwin_glue_bench;

    localparam int         TC    = 40;
    localparam logic [7:0] CLASS = 8'h5C;
    localparam logic [7:0] REV   = 8'h03;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       lc = 1'b0, hd = 1'b0;
    logic [7:0] rdata, sub_wdata, sub_rdata;
    logic [4:0] sub_cs;
    logic [3:0] sub_addr, irq_sel;
    logic       sub_rd, sub_wr, sub_rst, irq_out, iom_en;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    assign sub_rdata = 8'hA0 ^ {3'b000, sub_cs} ^ {sub_addr, 4'h0};

    hostwin_glue #(.CLASS_CODE(CLASS), .REV_CODE(REV), .TIMER_TC(TC)) u_hostwin_glue (
        .clk(clk), .rst(rst), .host_addr(addr), .host_rd(rd), .host_wr(wr),
        .host_wdata(wdata), .host_rdata(rdata), .sub_cs(sub_cs), .sub_addr(sub_addr),
        .sub_rd(sub_rd), .sub_wr(sub_wr), .sub_wdata(sub_wdata), .sub_rdata(sub_rdata),
        .sub_rst(sub_rst), .lc_irq(lc), .hdlc_irq(hd), .irq_out(irq_out),
        .iom_en(iom_en), .irq_line_sel(irq_sel)
    );

    // behavioural reference state
    logic [4:0] m_ctrl = '0;
    logic [7:0] m_cfg = '0;
    logic [2:0] m_sel = '0;
    int         m_cnt = 0;
    bit         m_pend = 0;

    always @(posedge clk) begin : model
        logic [4:0] oc;
        started = 1;
        oc = m_ctrl;
        if (rst) begin
            m_ctrl = '0; m_cfg = '0; m_sel = '0; m_cnt = 0; m_pend = 0;
        end else begin
            if (oc[2]) begin
                m_cnt = 0; m_pend = 0;
            end else if (!oc[1]) begin
                if (m_cnt == TC - 1) begin m_cnt = 0; m_pend = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wr && addr == 5'd2) m_ctrl = wdata[4:0];
            if (wr && addr == 5'd3) m_cfg = wdata;
            if (oc[0]) m_sel = '0;
            else if (wr && addr == 5'd4) m_sel = wdata[2:0];
        end
    end

    function automatic logic [4:0] sel_onehot(input logic [2:0] s);
        case (s)
            3'd0: return 5'b00001;
            3'd1: return 5'b00010;
            3'd2: return 5'b00100;
            3'd4: return 5'b01000;
            3'd6: return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [4:0] exp_cs();
        if (addr[4] && (rd || wr)) return sel_onehot(m_sel);
        return 5'b0;
    endfunction

    function automatic logic [7:0] exp_rdata();
        logic [4:0] oh;
        if (addr[4]) begin
            oh = sel_onehot(m_sel);
            if (oh == 5'b0) return 8'hFF;
            return 8'hA0 ^ {3'b000, exp_cs()} ^ {addr[3:0], 4'h0};
        end
        case (addr[3:0])
            4'd0: return CLASS;
            4'd1: return REV;
            4'd2: return {3'b000, m_ctrl[4], 1'b0, ~m_pend, ~hd, ~lc};
            4'd3: return m_cfg;
            4'd4: return {5'b0, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag();
        if (addr[4]) return "R4";
        case (addr[3:0])
            4'd0, 4'd1: return "R2";
            4'd2: return "R5";
            4'd3: return "R7";
            4'd4: return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            chk({7'b0, irq_out}, {7'b0, m_ctrl[3] & (lc | hd | m_pend)}, "R9");
            chk({7'b0, sub_rst}, {7'b0, m_ctrl[0]}, "R8");
            chk({3'b0, sub_cs}, {3'b0, exp_cs()}, "R3");
            chk({4'b0, sub_addr}, {4'b0, addr[3:0]}, "R4");
            chk({7'b0, sub_wr}, {7'b0, addr[4] & wr & (sel_onehot(m_sel) != 0)}, "R4");
            chk({7'b0, sub_rd}, {7'b0, addr[4] & rd & (sel_onehot(m_sel) != 0)}, "R4");
            chk({3'b0, iom_en, irq_sel}, {3'b0, m_cfg[7], m_cfg[3:0]}, "R7");
            chk(rdata, exp_rdata(), rd_tag());
        end
    end

    task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
        @(posedge clk); #1 addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1 wr = 1'b0;
    endtask

    task automatic check_rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1 addr = a; rd = 1'b1;
        @(negedge clk); chk(rdata, exp, tag);
        @(posedge clk); #1 rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check_rd(5'd2, 8'h07, "R1");
        check_rd(5'd4, 8'h00, "R1");
        check_rd(5'd3, 8'h00, "R1");
        chk({6'b0, irq_out, sub_rst}, 8'h00, "R1");

        // hold timer and reload it so it stays quiet
        do_wr(5'd2, 8'h06);
        do_wr(5'd2, 8'h02);

        // R2 fixed bytes, writes ignored
        check_rd(5'd0, CLASS, "R2");
        check_rd(5'd1, REV, "R2");
        do_wr(5'd0, 8'hFF);
        do_wr(5'd1, 8'hEE);
        check_rd(5'd0, CLASS, "R2");
        check_rd(5'd1, REV, "R2");

        // R3 selector decode with window reads
        for (int i = 0; i < 8; i++) begin
            logic [4:0] oh;
            logic [4:0] wa;
            do_wr(5'd4, 8'(i) | 8'hF8);
            check_rd(5'd4, 8'(i), "R3");
            oh = sel_onehot(3'(i));
            wa = 5'h10 | 5'(i * 3);
            check_rd(wa, (oh == 0) ? 8'hFF : (8'hA0 ^ {3'b000, oh} ^ {wa[3:0], 4'h0}), "R3");
        end

        // R4 window write strobe
        do_wr(5'd4, 8'd2);
        @(posedge clk); #1 addr = 5'h1B; wdata = 8'h3C; wr = 1'b1;
        @(negedge clk);
        chk({7'b0, sub_wr}, 8'h01, "R4");
        chk({3'b0, sub_cs}, 8'h04, "R4");
        chk({4'b0, sub_addr}, 8'h0B, "R4");
        chk(sub_wdata, 8'h3C, "R4");
        @(posedge clk); #1 wr = 1'b0;
        do_wr(5'd4, 8'd5);
        @(posedge clk); #1 addr = 5'h12; wr = 1'b1;
        @(negedge clk);
        chk({6'b0, sub_wr, sub_cs != 0}, 8'h00, "R4");
        @(posedge clk); #1 wr = 1'b0;

        // R5 active-low pending flags
        @(posedge clk); #1 lc = 1'b1;
        check_rd(5'd2, 8'h06, "R5");
        @(posedge clk); #1 hd = 1'b1;
        check_rd(5'd2, 8'h04, "R5");
        @(posedge clk); #1 lc = 1'b0;
        check_rd(5'd2, 8'h05, "R5");
        @(posedge clk); #1 hd = 1'b0;
        check_rd(5'd2, 8'h07, "R5");

        // R6 test bit echo
        do_wr(5'd2, 8'h12);
        check_rd(5'd2, 8'h17, "R6");
        do_wr(5'd2, 8'h02);
        check_rd(5'd2, 8'h07, "R6");

        // R7 configuration byte
        do_wr(5'd3, 8'h85);
        check_rd(5'd3, 8'h85, "R7");
        chk({3'b0, iom_en, irq_sel}, 8'h15, "R7");
        do_wr(5'd3, 8'h4A);
        check_rd(5'd3, 8'h4A, "R7");

        // R9 interrupt gating, combinational follow
        do_wr(5'd2, 8'h0A);
        @(posedge clk); #1 lc = 1'b1;
        @(negedge clk); chk({7'b0, irq_out}, 8'h01, "R9");
        @(posedge clk); #1 lc = 1'b0;
        @(negedge clk); chk({7'b0, irq_out}, 8'h00, "R9");
        do_wr(5'd2, 8'h02);
        @(posedge clk); #1 hd = 1'b1;
        @(negedge clk); chk({7'b0, irq_out}, 8'h00, "R9");
        @(posedge clk); #1 hd = 1'b0;

        // R8 device reset
        do_wr(5'd4, 8'd6);
        do_wr(5'd2, 8'h03);
        chk({7'b0, sub_rst}, 8'h01, "R8");
        check_rd(5'd4, 8'h00, "R8");
        do_wr(5'd4, 8'd2);
        check_rd(5'd4, 8'h00, "R8");
        do_wr(5'd2, 8'h02);
        check_rd(5'd4, 8'h00, "R8");
        do_wr(5'd4, 8'd2);
        check_rd(5'd4, 8'h02, "R8");

        // R10 timer
        do_wr(5'd2, 8'h0E);
        do_wr(5'd2, 8'h0A);
        repeat (TC + 5) @(posedge clk);
        check_rd(5'd2, 8'h07, "R10");
        do_wr(5'd2, 8'h08);
        repeat (TC + 3) @(posedge clk);
        check_rd(5'd2, 8'h03, "R10");
        chk({7'b0, irq_out}, 8'h01, "R10");
        repeat (TC) @(posedge clk);
        check_rd(5'd2, 8'h03, "R10");
        do_wr(5'd2, 8'h0C);
        do_wr(5'd2, 8'h0A);
        check_rd(5'd2, 8'h07, "R10");
        chk({7'b0, irq_out}, 8'h00, "R10");

        // R11 unused offsets
        check_rd(5'd5, 8'h00, "R11");
        check_rd(5'd15, 8'h00, "R11");
        do_wr(5'd9, 8'hAA);
        check_rd(5'd9, 8'h00, "R11");
        check_rd(5'd3, 8'h4A, "R11");

        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule